// File: doc/BRIEF.md
# Hit Cluster Flag and Size Generator

This block takes one wide word of binary hit bits, one bit per detector pad, and marks for every pad whether it opens a cluster and how large that cluster is. A cluster is a run of adjacent asserted pads counted toward higher indices, starting at pad 0 at the least significant bit. Each pad gets a 3-bit size and a head flag. A priority extractor downstream collects the head pads and reads their sizes. The size of any pad that is not a head is of no use to that consumer.

A run of hits longer than the largest size the field can hold is cut into chained clusters. The pad that follows a full seven-pad piece of a run becomes a new head. Chaining stops once a run reaches sixteen pads. Hits past that point are dropped: they open no cluster and add to no size. Bits above the top pad count as zero.

The word enters and leaves on valid/ready handshakes. By default one output register sits between the combinational marking logic and the output port. A held result stays frozen under back-pressure. The input is refused only while the output register is full and is not being drained. With the register disabled the block is purely combinational and the ready signal passes straight through.

Top module: `hit_cluster_marker`

## Requirements
- R1: For a pad that carries a counted hit, its size is the number of consecutive counted hits from that pad upward, saturated at 7. The size of pad i is out_size[3i+2:3i].
- R2: A pad with a hit is a head (out_primary[i] = 1) when the pad below it has no hit. Pad 0 is a head whenever it has a hit.
- R3: Inside a run, the pads with exactly 7 and exactly 14 consecutive hits directly below them are also heads. Each of them starts a new chained cluster.
- R4: A pad with 16 or more consecutive hits directly below it is never a head and is not counted in any size. A run of 16 pads therefore yields heads at run offsets 0, 7 and 14 with sizes 7, 7 and 2.
- R5: Bits above pad NUM_PADS-1 are taken as zero. The top pad's size is at most 1, and a run touching the top edge counts only the pads that exist.
- R6: A pad without a hit has out_primary = 0 and size 0.
- R7: A word moves in when in_valid and in_ready are both high at a clock edge, and moves out when out_valid and out_ready are both high. Every accepted word yields exactly one result, in order. While out_valid is high and out_ready is low, out_valid, out_primary and out_size hold.
- R8: With the output register enabled, in_ready equals (not out_valid) or out_ready. Reset clears out_valid, so in_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input hit word is offered |
| in_ready | output | 1 | The block takes the offered word at this edge |
| in_hits | input | NUM_PADS | Hit bits, pad 0 at bit 0 |
| out_valid | output | 1 | A marked result is present |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_primary | output | NUM_PADS | Head flag per pad |
| out_size | output | NUM_PADS*3 | Size per pad, pad i at bits 3i+2..3i |

## Verification
Two things can happen in the same clock edge: a result leaves the output register and the next word enters it. When that happens, neither may be lost or duplicated. The bench provokes this by offering words back to back while out_ready toggles at random. This produces drain-and-refill edges, stalls that hold a result, and stalls that refuse the input. A scoreboard of expected results, built by a bit-serial reference scan, checks every result for order and content. A separate check confirms that a held result does not change while stalled.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
  localparam int DEF_PADS        = 192;
  localparam int DEF_SIZE_W      = 3;
  localparam int DEF_CHAIN_LIMIT = 16;

  // A pad opens a (chained) cluster when the hits below it form a whole
  // number of full-size pieces and the run has not yet reached the limit.
  function automatic logic is_chain_head(input int below, input int max_size,
                                         input int limit);
    return (below < limit) && ((below % max_size) == 0);
  endfunction
endpackage

// File: rtl/hcm_run_below.sv
// Per pad: number of consecutive hits directly below, saturated at LIMIT.
module hcm_run_below #(
  parameter int NUM_PADS = 192,
  parameter int LIMIT    = 16,
  localparam int OFF_W   = $clog2(LIMIT + 1)
) (
  input  logic [NUM_PADS-1:0]       hits,
  output logic [NUM_PADS*OFF_W-1:0] below
);
  logic [NUM_PADS+LIMIT-1:0] ext;
  assign ext = {hits, {LIMIT{1'b0}}};

  for (genvar gi = 0; gi < NUM_PADS; gi++) begin : g_pad
    logic [OFF_W-1:0] cnt;
    always_comb begin
      logic go;
      go  = 1'b1;
      cnt = '0;
      for (int k = 1; k <= LIMIT; k++) begin
        if (go && ext[gi + LIMIT - k]) cnt = cnt + OFF_W'(1);
        else go = 1'b0;
      end
    end
    assign below[gi*OFF_W +: OFF_W] = cnt;
  end
endmodule

// File: rtl/hcm_head_mark.sv
// Per pad: counted-hit flag and head flag.
module hcm_head_mark #(
  parameter int NUM_PADS = 192,
  parameter int SIZE_W   = 3,
  parameter int LIMIT    = 16,
  localparam int OFF_W    = $clog2(LIMIT + 1),
  localparam int MAX_SIZE = (1 << SIZE_W) - 1
) (
  input  logic [NUM_PADS-1:0]       hits,
  input  logic [NUM_PADS*OFF_W-1:0] below,
  output logic [NUM_PADS-1:0]       counted,
  output logic [NUM_PADS-1:0]       head
);
  import hcm_pkg::*;

  for (genvar gi = 0; gi < NUM_PADS; gi++) begin : g_pad
    logic [OFF_W-1:0] off;
    assign off          = below[gi*OFF_W +: OFF_W];
    assign counted[gi]  = hits[gi] && (int'(off) < LIMIT);
    assign head[gi]     = hits[gi] && is_chain_head(int'(off), MAX_SIZE, LIMIT);
  end
endmodule

// File: rtl/hcm_size_count.sv
// Per pad: consecutive counted hits from the pad upward, saturated.
module hcm_size_count #(
  parameter int NUM_PADS = 192,
  parameter int SIZE_W   = 3,
  localparam int MAX_SIZE = (1 << SIZE_W) - 1
) (
  input  logic [NUM_PADS-1:0]        counted,
  output logic [NUM_PADS*SIZE_W-1:0] size
);
  logic [NUM_PADS+MAX_SIZE-1:0] ext;
  assign ext = {{MAX_SIZE{1'b0}}, counted};

  for (genvar gi = 0; gi < NUM_PADS; gi++) begin : g_pad
    logic [SIZE_W-1:0] cnt;
    always_comb begin
      logic go;
      go  = 1'b1;
      cnt = '0;
      for (int k = 0; k < MAX_SIZE; k++) begin
        if (go && ext[gi + k]) cnt = cnt + SIZE_W'(1);
        else go = 1'b0;
      end
    end
    assign size[gi*SIZE_W +: SIZE_W] = cnt;
  end
endmodule

// File: rtl/hit_cluster_marker.sv
module hit_cluster_marker #(
  parameter int NUM_PADS    = hcm_pkg::DEF_PADS,
  parameter int SIZE_W      = hcm_pkg::DEF_SIZE_W,
  parameter int CHAIN_LIMIT = hcm_pkg::DEF_CHAIN_LIMIT,
  parameter bit REG_OUT     = 1'b1,
  localparam int OFF_W    = $clog2(CHAIN_LIMIT + 1),
  localparam int MAX_SIZE = (1 << SIZE_W) - 1,
  localparam int SZ_BITS  = NUM_PADS * SIZE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NUM_PADS-1:0] in_hits,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NUM_PADS-1:0] out_primary,
  output logic [SZ_BITS-1:0]  out_size
);
  logic [NUM_PADS*OFF_W-1:0] below;
  logic [NUM_PADS-1:0]       counted;
  logic [NUM_PADS-1:0]       head;
  logic [SZ_BITS-1:0]        size;

  hcm_run_below #(.NUM_PADS(NUM_PADS), .LIMIT(CHAIN_LIMIT)) u_below (
    .hits(in_hits), .below(below));

  hcm_head_mark #(.NUM_PADS(NUM_PADS), .SIZE_W(SIZE_W), .LIMIT(CHAIN_LIMIT)) u_mark (
    .hits(in_hits), .below(below), .counted(counted), .head(head));

  hcm_size_count #(.NUM_PADS(NUM_PADS), .SIZE_W(SIZE_W)) u_size (
    .counted(counted), .size(size));

  if (REG_OUT) begin : g_reg
    logic                take;
    logic                v_q;
    logic [NUM_PADS-1:0] p_q;
    logic [SZ_BITS-1:0]  s_q;

    assign in_ready = !v_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (in_ready) begin
        v_q <= in_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        p_q <= head;
        s_q <= size;
      end
    end

    assign out_valid   = v_q;
    assign out_primary = p_q;
    assign out_size    = s_q;

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_primary) && $stable(out_size));
    assert_accept_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    assert_empty_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end else begin : g_comb
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_primary = head;
    assign out_size    = size;
  end

  for (genvar gi = 0; gi < NUM_PADS; gi++) begin : g_chk
    if (gi == 0) begin : g_low
      assert_pad0_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_hits[0] |-> head[0]);
    end else begin : g_mid
      assert_run_start_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_hits[gi] && !in_hits[gi-1] |-> head[gi]);
    end
    assert_head_has_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
      head[gi] |-> in_hits[gi] && (size[gi*SIZE_W +: SIZE_W] != '0));
    if (gi < NUM_PADS - 1) begin : g_chain
      assert_size_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        counted[gi] && counted[gi+1] |->
          (size[gi*SIZE_W +: SIZE_W] ==
           ((size[(gi+1)*SIZE_W +: SIZE_W] == SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE)
              : size[(gi+1)*SIZE_W +: SIZE_W] + SIZE_W'(1))));
    end else begin : g_top
      assert_top_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        size[gi*SIZE_W +: SIZE_W] <= SIZE_W'(1));
    end
  end
endmodule

// File: tb/hit_cluster_marker_test.sv
module hit_cluster_marker_test;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 192;
  localparam int SW   = 3;
  localparam int MAXS = 7;
  localparam int LIM  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [N-1:0]   in_hits = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [N-1:0]   out_primary;
  logic [N*SW-1:0] out_size;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done    = 0;

  logic [N-1:0]    q_prim[$];
  logic [N*SW-1:0] q_size[$];
  logic [N-1:0]    q_hits[$];
  string           q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_cluster_marker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hits(in_hits), .out_valid(out_valid), .out_ready(out_ready),
    .out_primary(out_primary), .out_size(out_size));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [N*SW-1:0] act, input logic [N*SW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Bit-serial reference scan built from the requirements.
  task automatic ref_model(input logic [N-1:0] h, output logic [N-1:0] prim,
                           output logic [N*SW-1:0] sz);
    logic [N-1:0] cnt_ok;
    int run;
    int up;
    run = 0;
    for (int i = 0; i < N; i++) begin
      if (h[i]) begin
        cnt_ok[i] = (run < LIM);
        prim[i]   = (run < LIM) && (run % MAXS == 0);
        run++;
      end else begin
        cnt_ok[i] = 1'b0;
        prim[i]   = 1'b0;
        run = 0;
      end
    end
    up = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cnt_ok[i]) up = (up < MAXS) ? up + 1 : MAXS;
      else up = 0;
      sz[i*SW +: SW] = SW'(up);
    end
  endtask

  task automatic send(input logic [N-1:0] h, input string tag);
    logic [N-1:0]    p;
    logic [N*SW-1:0] s;
    ref_model(h, p, s);
    in_valid = 1'b1;
    in_hits  = h;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    q_prim.push_back(p);
    q_size.push_back(s);
    q_hits.push_back(h);
    q_tag.push_back(tag);
    @(negedge clk); #2;
    in_valid = 1'b0;
  endtask

  function automatic logic [N-1:0] run_at(input int start, input int len);
    logic [N-1:0] v;
    v = '0;
    for (int i = start; i < start + len && i < N; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [N-1:0] rnd_word();
    logic [N-1:0] v;
    for (int w = 0; w < N / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // Monitor / scoreboard at the falling edge.
  logic            held = 1'b0;
  logic [N-1:0]    held_p;
  logic [N*SW-1:0] held_s;

  always @(negedge clk) begin
    if (started) begin
      check(in_ready == (!out_valid || out_ready), "R8", "in_ready rule",
            {{(N*SW-1){1'b0}}, in_ready}, {{(N*SW-1){1'b0}}, (!out_valid || out_ready)});
      if (held)
        check(out_valid && out_primary == held_p && out_size == held_s, "R7",
              "stalled result changed", {out_size, out_primary}, {held_s, held_p});
      out_ready = ($urandom % 4) != 0;
      held   = out_valid && !out_ready;
      held_p = out_primary;
      held_s = out_size;
      if (out_valid && out_ready) begin
        if (q_prim.size() == 0) begin
          check(1'b0, "R7", "result without input", {{(N*SW-N){1'b0}}, out_primary}, '0);
        end else begin
          logic [N-1:0]    ep;
          logic [N*SW-1:0] es;
          logic [N-1:0]    eh;
          string           tg;
          bit              sz_ok;
          ep = q_prim.pop_front();
          es = q_size.pop_front();
          eh = q_hits.pop_front();
          tg = q_tag.pop_front();
          check(out_primary == ep, tg, "head flags",
                {{(N*SW-N){1'b0}}, out_primary}, {{(N*SW-N){1'b0}}, ep});
          sz_ok = 1'b1;
          for (int i = 0; i < N; i++)
            if ((ep[i] || !eh[i]) && out_size[i*SW +: SW] != es[i*SW +: SW]) sz_ok = 1'b0;
          check(sz_ok, tg, "sizes at heads and empty pads", out_size, es);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    rst_n = 1'b1;
    check(!out_valid, "R8", "out_valid after reset", {{(N*SW-1){1'b0}}, out_valid}, '0);
    check(in_ready, "R8", "in_ready after reset", {{(N*SW-1){1'b0}}, in_ready}, 1);
    started = 1;
    send('0, "R6");
    send('1, "R4");
    send({(N/2){2'b01}}, "R2");
    send({(N/2){2'b10}}, "R6");
    send(run_at(20, 7), "R3");
    send(run_at(40, 8), "R3");
    send(run_at(60, 15), "R3");
    send(run_at(90, 16), "R4");
    send(run_at(120, 20), "R4");
    send(run_at(0, 9), "R2");
    send(run_at(N - 3, 3), "R5");
    send(run_at(N - 1, 1), "R5");
    send(run_at(N - 10, 10), "R5");
    send(run_at(30, 4) | run_at(35, 6) | run_at(42, 1), "R1");
    for (int n = 0; n < 40; n++) begin
      logic [N-1:0] a;
      logic [N-1:0] b;
      a = rnd_word();
      b = rnd_word();
      send((n % 2) ? (a | b) : (a & b), "R1");
    end
    while (q_prim.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_prim.size() == 0, "R7", "results outstanding", '0, '0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule